// File: doc/BRIEF.md
# Fractional-N Lock Indicator

This block produces the lock-detect output of a fractional-N synthesizer. It runs on the reference clock and watches the up and down pulses of the phase/frequency detector. A compare strobe marks the end of each comparison interval. The block turns each interval into a phase error, counted in whole reference cycles, and judges that error against a selectable window.

A select input picks the output source. In one setting the raw OR of the detector pulses goes straight to the output. In the other setting a hysteresis state machine drives the output. That machine needs a long unbroken run of in-window comparisons before it reports lock. It needs an equally long unbroken run of out-of-window comparisons before it drops lock.

Any write of a new frequency forces the indication low and starts the measurement over.

Top module: `fracn_lock_monitor`

## Requirements
- R1: When `mode_analog` is 1, `lock_out` equals `pd_up | pd_dn` in the same cycle, with no register in the path.
- R2: When `mode_analog` is 0, `lock_out` is the registered lock flag (1 = locked) and does not follow the detector pulses.
- R3: The phase error of one comparison is the number of clock cycles in which `pd_up` or `pd_dn` is high. The count runs from the cycle after the previous strobe up to and including the cycle in which `cmp_strobe` is high. The count restarts after every strobe.
- R4: `win_sel` values 0, 1 and 2 give a window T of 1, 2 and 3 cycles. A comparison is in window when its error is less than T. An error equal to or above T is out of window.
- R5: The reserved `win_sel` value 3 acts as a window of 3 cycles.
- R6: While unlocked, the 63rd consecutive in-window comparison sets the lock flag. The flag is visible the cycle after that strobe.
- R7: While unlocked, an out-of-window comparison restarts the run of in-window comparisons from zero.
- R8: While locked, the 63rd consecutive out-of-window comparison clears the lock flag. An in-window comparison restarts that run from zero.
- R9: A cycle with `freq_wr` high clears the lock flag, the run count and any partly measured pulse width. It takes priority over a strobe in the same cycle.
- R10: After reset the block is unlocked with a run count of zero, so `lock_out` is 0 in digital mode.
- R11: The pulse-width count saturates at its maximum (15 with default parameters) instead of wrapping. A pulse of 16 or more cycles is therefore out of window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_strobe | input | 1 | High for the last cycle of each comparison interval |
| pd_up | input | 1 | Phase detector up pulse |
| pd_dn | input | 1 | Phase detector down pulse |
| mode_analog | input | 1 | 1 = raw detector passthrough, 0 = digital lock flag |
| win_sel | input | 2 | Lock window select (0..2 → 1..3 cycles, 3 → 3 cycles) |
| freq_wr | input | 1 | New frequency written; forces unlock |
| lock_out | output | 1 | Lock-detect output |

## Verification
The bench aims at the edges of the 63-count run.

- **Off-by-one run length.** The output is checked after 62 comparisons and again after the 63rd. A design that counts one too many or one too few shows the wrong value at exactly one of those points.
- **Window boundary.** Pulse widths of exactly T and T-1 are applied for every select value, including the reserved one. A design that puts the boundary on the wrong side locks where it must not.
- **Width-count wrap.** A 16-cycle pulse is applied. A counter that wraps would read it as a zero error and lock.
- **Frequency write.** A write is issued mid-pulse, and another together with a strobe. A design that keeps the partial width, or lets the strobe win, locks late or locks early.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    typedef enum logic {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lk_state_e;

    typedef struct packed {
        logic valid;   // a comparison ends this cycle
        logic in_win;  // its error is below the window
    } cmp_result_t;

    // window width in reference cycles; the reserved code maps to the widest
    function automatic logic [1:0] win_cycles(input logic [1:0] sel);
        logic [1:0] t;
        case (sel)
            2'd0:    t = 2'd1;
            2'd1:    t = 2'd2;
            default: t = 2'd3;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/lkd_width_meter.sv
module lkd_width_meter
    import lkd_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        strobe,
    input  logic        active,
    input  logic [1:0]  win_sel,
    output cmp_result_t result
);
    localparam logic [ERR_W-1:0] ACC_MAX = {ERR_W{1'b1}};

    logic [ERR_W-1:0] acc;
    logic [ERR_W-1:0] cur;
    logic [ERR_W-1:0] limit;

    // width including the present cycle, held at the top value
    always_comb begin
        cur   = (active && acc != ACC_MAX) ? acc + 1'b1 : acc;
        limit = ERR_W'(win_cycles(win_sel));
        result.valid  = strobe;
        result.in_win = (cur < limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || strobe) begin
            acc <= '0;
        end else begin
            acc <= cur;
        end
    end

    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
        (strobe || clr) |=> (acc == '0));  // R3

    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_MAX && !strobe && !clr) |=> (acc == ACC_MAX));  // R11

endmodule

// File: rtl/lkd_hysteresis.sv
module lkd_hysteresis
    import lkd_pkg::*;
#(
    parameter int HYST_N = 63
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  cmp_result_t result,
    output logic        locked
);
    localparam int               CNT_W = $clog2(HYST_N + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(HYST_N - 1);
    localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};

    lk_state_e        st;
    logic [CNT_W-1:0] run;
    logic             agree;

    // a comparison agrees when it argues for leaving the present state
    always_comb begin
        agree = (st == ST_UNLOCKED) ? result.in_win : !result.in_win;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st  <= ST_UNLOCKED;
            run <= '0;
        end else if (result.valid) begin
            if (!agree) begin
                run <= '0;
            end else if (run == LAST) begin
                st  <= (st == ST_LOCKED) ? ST_UNLOCKED : ST_LOCKED;
                run <= '0;
            end else if (run != CMAX) begin
                run <= run + 1'b1;
            end
        end
    end

    assign locked = (st == ST_LOCKED);

    AST_WRITE_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !locked);  // R9

    AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run < CNT_W'(HYST_N));  // R6

    AST_LOCK_NEEDS_INWIN: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(result.valid && result.in_win));  // R6

    AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(clr || (result.valid && !result.in_win)));  // R8

endmodule

// File: rtl/fracn_lock_monitor.sv
module fracn_lock_monitor
    import lkd_pkg::*;
#(
    parameter int ERR_W  = 4,
    parameter int HYST_N = 63
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp_strobe,
    input  logic       pd_up,
    input  logic       pd_dn,
    input  logic       mode_analog,
    input  logic [1:0] win_sel,
    input  logic       freq_wr,
    output logic       lock_out
);
    cmp_result_t cmp_res;
    logic        pd_any;
    logic        locked;

    assign pd_any = pd_up | pd_dn;

    lkd_width_meter #(.ERR_W(ERR_W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .clr     (freq_wr),
        .strobe  (cmp_strobe),
        .active  (pd_any),
        .win_sel (win_sel),
        .result  (cmp_res)
    );

    lkd_hysteresis #(.HYST_N(HYST_N)) u_hyst (
        .clk    (clk),
        .rst    (rst),
        .clr    (freq_wr),
        .result (cmp_res),
        .locked (locked)
    );

    assign lock_out = mode_analog ? pd_any : locked;

    AST_DIGITAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mode_analog && $past(!mode_analog) && !$past(cmp_strobe) && !$past(freq_wr))
        |-> $stable(lock_out));  // R2

endmodule

// File: tb/sim_fracn_lock_monitor.sv
module sim_fracn_lock_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_strobe = 1'b0;
    logic       pd_up = 1'b0;
    logic       pd_dn = 1'b0;
    logic       mode_analog = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic       freq_wr = 1'b0;
    logic       lock_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;  // 125 MHz

    fracn_lock_monitor u0 (
        .clk(clk), .rst(rst), .cmp_strobe(cmp_strobe), .pd_up(pd_up),
        .pd_dn(pd_dn), .mode_analog(mode_analog), .win_sel(win_sel),
        .freq_wr(freq_wr), .lock_out(lock_out)
    );

    // {win_sel[1:0], pulse width[4:0], expected lock}
    localparam logic [7:0] VEC [0:7] = '{
        {2'd0, 5'd0, 1'b1}, {2'd0, 5'd1, 1'b0},
        {2'd1, 5'd1, 1'b1}, {2'd1, 5'd2, 1'b0},
        {2'd2, 5'd2, 1'b1}, {2'd2, 5'd3, 1'b0},
        {2'd3, 5'd2, 1'b1}, {2'd3, 5'd3, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lock_out=%0b expected %0b", req, act, exp);
        end
    endtask

    // w cycles of up pulse, then a strobe cycle: error of exactly w
    task automatic cmp(input int w);
        for (int i = 0; i < w; i++) begin
            pd_up = 1'b1;
            @(negedge clk);
        end
        pd_up = 1'b0;
        cmp_strobe = 1'b1;
        @(negedge clk);
        cmp_strobe = 1'b0;
    endtask

    task automatic cmp_n(input int n, input int w);
        for (int i = 0; i < n; i++) cmp(w);
    endtask

    task automatic fwrite();
        freq_wr = 1'b1;
        @(negedge clk);
        freq_wr = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset unlocked", lock_out, 1'b0);

        // table walk: R4/R5 window boundary and R6 run length
        for (int v = 0; v < 8; v++) begin
            win_sel = VEC[v][7:6];
            fwrite();
            cmp_n(62, int'(VEC[v][5:1]));
            chk("R6 not yet after 62", lock_out, 1'b0);
            cmp(int'(VEC[v][5:1]));
            chk((v >= 6) ? "R5 reserved window" : "R4 window", lock_out, VEC[v][0]);
        end

        // R1 analog passthrough
        mode_analog = 1'b1;
        pd_up = 1'b1; #1;
        chk("R1 up passes", lock_out, 1'b1);
        pd_up = 1'b0; pd_dn = 1'b1; #1;
        chk("R1 down passes", lock_out, 1'b1);
        pd_dn = 1'b0; #1;
        chk("R1 idle low", lock_out, 1'b0);
        @(negedge clk);
        mode_analog = 1'b0;

        // R2 digital ignores raw pulses
        win_sel = 2'd0;
        fwrite();
        pd_dn = 1'b1; #1;
        chk("R2 no passthrough", lock_out, 1'b0);
        pd_dn = 1'b0;
        @(negedge clk);

        // R7 out-of-window comparison restarts the run
        win_sel = 2'd1;
        fwrite();
        cmp_n(40, 0);
        cmp(2);
        cmp_n(62, 1);
        chk("R7 run restarted", lock_out, 1'b0);
        cmp(1);
        chk("R7 lock after fresh 63", lock_out, 1'b1);

        // R8 leaving lock needs 63 consecutive out-of-window
        cmp_n(62, 3);
        chk("R8 still locked at 62", lock_out, 1'b1);
        cmp(0);
        cmp_n(62, 3);
        chk("R8 run restarted", lock_out, 1'b1);
        cmp(3);
        chk("R8 unlock on 63rd", lock_out, 1'b0);

        // R9 write drops lock
        win_sel = 2'd0;
        cmp_n(63, 0);
        chk("R9 locked before write", lock_out, 1'b1);
        fwrite();
        chk("R9 write unlocks", lock_out, 1'b0);

        // R9 write beats a strobe in the same cycle
        cmp_n(62, 0);
        cmp_strobe = 1'b1; freq_wr = 1'b1;
        @(negedge clk);
        cmp_strobe = 1'b0; freq_wr = 1'b0;
        chk("R9 write has priority", lock_out, 1'b0);

        // R9 partial pulse discarded by a write
        fwrite();
        pd_up = 1'b1;
        repeat (2) @(negedge clk);
        pd_up = 1'b0;
        fwrite();
        cmp(0);
        cmp_n(62, 0);
        chk("R9 partial width cleared", lock_out, 1'b1);

        // R11 saturation: 16-cycle pulse must stay out of window
        fwrite();
        cmp_n(62, 0);
        cmp(16);
        chk("R11 no wrap", lock_out, 1'b0);
        cmp_n(62, 0);
        chk("R11 run restarted", lock_out, 1'b0);

        // R10 reset clears a lock
        cmp(0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset clears lock", lock_out, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule